// File: doc/BRIEF.md
# Serializer Power and Clock-Stop Controller

This block decides when a parallel-to-serial link transmitter may drive its line. It runs on a free-running reference clock. It watches two things: an active-low power-down input from the host, and the toggling of the pixel clock that feeds the transmitter. From these it keeps one of four power states. OFF means the host has powered the link down. SLEEP means the pixel clock has stopped or is too slow. LOCKING means the clock has come back and is being confirmed. ACTIVE means the transmitter is enabled.

The two low-power states treat configuration differently. A host power-down returns every configuration register to its default value and emits a one-cycle reset strobe. A sleep caused by the clock stopping leaves the register contents untouched.

Clock presence is judged once per window of `WIN_CYC` reference cycles. The block counts rising edges of the synchronized pixel clock in that window. The defaults are a 250-cycle window at 125 MHz and a threshold of 6 edges, which sets the cut-off at 3 MHz. Lock is modelled as `LOCK_WINS` consecutive passing windows. The configuration port is a plain register write/read port with no handshake. A write always completes in one cycle, so there is no back-pressure.

Top module: `sertx_power_ctrl`

## Requirements
- R1: While `link_en` is low, `pwr_state` is 0 (OFF), `tx_en` is 0 and `line_idle` is 1. The state reaches OFF one cycle after `link_en` is sampled low.
- R2: A high-to-low step of `link_en` outside OFF raises `cfg_rst` for exactly one cycle. While the block is in OFF, every register is forced to its default value (register i defaults to 0x11 times i) and writes are ignored.
- R3: Each window counts the rising edges of `mon_clk`. The window passes when it holds at least `MIN_EDGES` edges, and `clk_present` shows the result of the last window. A failing window in ACTIVE moves the block to SLEEP.
- R4: Stop detection works on missing edges only. A clock parked high and a clock parked low both lead to SLEEP.
- R5: While the block is in SLEEP, LOCKING or ACTIVE, no register changes unless it is written.
- R6: In SLEEP, a passing window moves the block to LOCKING (state 2). The block then needs exactly `LOCK_WINS` further passing windows before it reaches ACTIVE (state 3). `tx_en` is 1 only in ACTIVE, and `line_idle` is the inverse of `tx_en`.
- R7: A failing window in LOCKING returns the block to SLEEP (state 1) without passing through ACTIVE.
- R8: `cap_rising` gives the capture edge (1 = rising, 0 = falling). When bit 1 of register 0 is set, `cap_rising` follows bit 0 of register 0. Otherwise it follows `edge_pin`.
- R9: In OFF, when `link_en` is high at a clock edge, the next state is LOCKING if `clk_present` is 1 and SLEEP if it is 0.
- R10: `cfg_rdata` shows the register selected by `cfg_addr` combinationally. A write that is accepted is visible one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Host enable, low requests power-down (synchronous to ref_clk) |
| mon_clk | input | 1 | Monitored pixel clock, treated as asynchronous data |
| edge_pin | input | 1 | Pin setting for capture edge, 1 = rising |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register index |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data |
| clk_present | output | 1 | Last window met the edge threshold |
| pwr_state | output | 2 | 0 OFF, 1 SLEEP, 2 LOCKING, 3 ACTIVE |
| tx_en | output | 1 | Transmitter enable |
| line_idle | output | 1 | Request line outputs to zero-swing idle |
| cfg_rst | output | 1 | One-cycle configuration reset strobe |
| cap_rising | output | 1 | Selected capture edge, 1 = rising |

## Verification
A stuck or wrong edge counter does not show at once. It appears only at the next window boundary, as a wrong `clk_present`. One window later it appears as a `pwr_state` that never leaves SLEEP, or that drops out of ACTIVE. The bench therefore waits several windows before it judges a state. A lock counter that is off by one shows as a LOCKING interval that differs from `LOCK_WINS` windows by one window, so the bench measures that interval to the cycle. Register clearing and retention show at the read port within two cycles of entering OFF. They must also still show after a full SLEEP and relock cycle.

// File: rtl/sertx_pwr_pkg.sv
package sertx_pwr_pkg;
  typedef enum logic [1:0] {
    PS_OFF     = 2'd0,
    PS_SLEEP   = 2'd1,
    PS_LOCKING = 2'd2,
    PS_ACTIVE  = 2'd3
  } pwr_state_e;

  // register 0 control bits (capture edge selection)
  localparam int SEL_VAL_BIT = 0;
  localparam int SEL_OVR_BIT = 1;

  // reset value of configuration register idx
  function automatic logic [31:0] cfg_default(input int unsigned idx);
    return 32'(idx * 17);
  endfunction
endpackage

// File: rtl/sertx_clk_mon.sv
module sertx_clk_mon #(
  parameter int WIN_CYC   = 250,
  parameter int MIN_EDGES = 6
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic mon_clk,
  output logic win_done,
  output logic win_pass
);
  localparam int WW = $clog2(WIN_CYC);
  localparam int EW = $clog2(MIN_EDGES + 1);

  logic          sync1, sync2, sync3;
  logic [WW-1:0] win_cnt;
  logic [EW-1:0] edge_cnt;
  logic          rise, last, edge_sat, pass_now;
  logic [EW:0]   total;

  // two-flop synchronizer plus one history flop for edge detection
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      sync3 <= 1'b0;
    end else begin
      sync1 <= mon_clk;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  assign rise     = sync2 & ~sync3;
  assign last     = (win_cnt == WW'(WIN_CYC - 1));
  assign edge_sat = (edge_cnt == EW'(MIN_EDGES));
  assign total    = {1'b0, edge_cnt} + {{EW{1'b0}}, rise};
  assign pass_now = (total >= (EW + 1)'(MIN_EDGES));

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      win_done <= 1'b0;
      win_pass <= 1'b0;
    end else begin
      win_done <= last;
      if (last) begin
        win_cnt  <= '0;
        edge_cnt <= '0;
        win_pass <= pass_now;
      end else begin
        win_cnt <= win_cnt + 1'b1;
        if (rise && !edge_sat) edge_cnt <= edge_cnt + 1'b1;
      end
    end
  end

  // R3
  win_pulse_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    win_done |=> !win_done);
  // R3
  sat_pass_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (last && edge_sat) |=> (win_pass && win_done));
  // R4
  result_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !win_done |=> $stable(win_pass) || win_done);
endmodule

// File: rtl/sertx_pwr_fsm.sv
module sertx_pwr_fsm
  import sertx_pwr_pkg::*;
#(
  parameter int LOCK_WINS = 3
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       link_en,
  input  logic       win_done,
  input  logic       win_pass,
  output pwr_state_e state,
  output logic       cfg_rst
);
  localparam int LW = $clog2(LOCK_WINS + 1);

  pwr_state_e    nxt;
  logic [LW-1:0] lock_cnt, lock_nxt;

  always_comb begin
    nxt      = state;
    lock_nxt = lock_cnt;
    if (!link_en) begin
      nxt      = PS_OFF;
      lock_nxt = '0;
    end else begin
      unique case (state)
        PS_OFF: begin
          nxt      = win_pass ? PS_LOCKING : PS_SLEEP;
          lock_nxt = '0;
        end
        PS_SLEEP: begin
          if (win_done && win_pass) begin
            nxt      = PS_LOCKING;
            lock_nxt = '0;
          end
        end
        PS_LOCKING: begin
          if (win_done) begin
            if (!win_pass) nxt = PS_SLEEP;
            else if (lock_cnt == LW'(LOCK_WINS - 1)) nxt = PS_ACTIVE;
            else lock_nxt = lock_cnt + 1'b1;
          end
        end
        PS_ACTIVE: begin
          if (win_done && !win_pass) nxt = PS_SLEEP;
        end
        default: nxt = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PS_OFF;
      lock_cnt <= '0;
      cfg_rst  <= 1'b0;
    end else begin
      state    <= nxt;
      lock_cnt <= lock_nxt;
      cfg_rst  <= (state != PS_OFF) && !link_en;
    end
  end

  // R1
  off_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !link_en |=> state == PS_OFF);
  // R2
  rst_pulse_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cfg_rst |=> !cfg_rst);
  // R3
  active_drop_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (state == PS_ACTIVE && link_en && win_done && !win_pass) |=> state == PS_SLEEP);
  // R7
  lock_fail_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (state == PS_LOCKING && link_en && win_done && !win_pass) |=> state == PS_SLEEP);
  // R9
  release_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (state == PS_OFF && link_en) |=>
      state == ($past(win_pass) ? PS_LOCKING : PS_SLEEP));
endmodule

// File: rtl/sertx_cfg_bank.sv
module sertx_cfg_bank
  import sertx_pwr_pkg::*;
#(
  parameter int NREGS = 4,
  parameter int DW    = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic          hold_def,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] ctrl0
);
  logic [DW-1:0] regs [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    localparam logic [DW-1:0] DEF = DW'(cfg_default(i));
    always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n)                          regs[i] <= DEF;
      else if (hold_def)                   regs[i] <= DEF;
      else if (we && addr == AW'(i))       regs[i] <= wdata;
    end

    // R2
    clr_def_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      hold_def |=> regs[i] == DEF);
    // R5
    retain_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (!hold_def && !(we && addr == AW'(i))) |=> $stable(regs[i]));
  end

  assign rdata = regs[addr];
  assign ctrl0 = regs[0];
endmodule

// File: rtl/sertx_power_ctrl.sv
module sertx_power_ctrl
  import sertx_pwr_pkg::*;
#(
  parameter int WIN_CYC   = 250,
  parameter int MIN_EDGES = 6,
  parameter int LOCK_WINS = 3,
  parameter int NREGS     = 4,
  parameter int DW        = 8,
  localparam int AW       = $clog2(NREGS)
) (
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic          link_en,
  input  logic          mon_clk,
  input  logic          edge_pin,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          clk_present,
  output logic [1:0]    pwr_state,
  output logic          tx_en,
  output logic          line_idle,
  output logic          cfg_rst,
  output logic          cap_rising
);
  logic          win_done, win_pass;
  pwr_state_e    state;
  logic [DW-1:0] ctrl0;

  sertx_clk_mon #(.WIN_CYC(WIN_CYC), .MIN_EDGES(MIN_EDGES)) u_mon (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .mon_clk (mon_clk),
    .win_done(win_done),
    .win_pass(win_pass)
  );

  sertx_pwr_fsm #(.LOCK_WINS(LOCK_WINS)) u_fsm (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .link_en (link_en),
    .win_done(win_done),
    .win_pass(win_pass),
    .state   (state),
    .cfg_rst (cfg_rst)
  );

  sertx_cfg_bank #(.NREGS(NREGS), .DW(DW)) u_bank (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .hold_def(state == PS_OFF),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .ctrl0   (ctrl0)
  );

  assign clk_present = win_pass;
  assign pwr_state   = state;
  assign tx_en       = (state == PS_ACTIVE);
  assign line_idle   = !tx_en;
  assign cap_rising  = ctrl0[SEL_OVR_BIT] ? ctrl0[SEL_VAL_BIT] : edge_pin;

  // R6
  tx_start_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(tx_en) |-> clk_present);
  // R6
  tx_from_lock_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(state) == PS_LOCKING);
endmodule

// File: tb/sertx_power_ctrl_bench.sv
module sertx_power_ctrl_bench;
  localparam int WIN  = 250;
  localparam int LOCKW = 3;

  logic       ref_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       link_en = 1'b0;
  logic       mon_clk = 1'b0;
  logic       edge_pin = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       clk_present, tx_en, line_idle, cfg_rst, cap_rising;
  logic [1:0] pwr_state;

  int mon_half = 0;
  logic mon_park = 1'b0;
  int checks = 0;
  int failures = 0;

  sertx_power_ctrl u_sertx_power_ctrl (
    .ref_clk(ref_clk), .rst_n(rst_n), .link_en(link_en), .mon_clk(mon_clk),
    .edge_pin(edge_pin), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .clk_present(clk_present),
    .pwr_state(pwr_state), .tx_en(tx_en), .line_idle(line_idle),
    .cfg_rst(cfg_rst), .cap_rising(cap_rising)
  );

  always #4ns ref_clk = ~ref_clk;

  always begin
    if (mon_half == 0) begin
      mon_clk = mon_park;
      #4ns;
    end else begin
      #(mon_half * 1ns);
      mon_clk = ~mon_clk;
    end
  end

  // {en, park, half-period ns, expected state, expected presence, pad}
  localparam logic [23:0] VECS [8] = '{
    {1'b1, 1'b0, 16'd50,  2'd3, 1'b1, 3'd0},
    {1'b1, 1'b1, 16'd0,   2'd1, 1'b0, 3'd0},
    {1'b1, 1'b0, 16'd100, 2'd3, 1'b1, 3'd0},
    {1'b1, 1'b0, 16'd0,   2'd1, 1'b0, 3'd0},
    {1'b1, 1'b0, 16'd250, 2'd1, 1'b0, 3'd0},
    {1'b0, 1'b0, 16'd50,  2'd0, 1'b1, 3'd0},
    {1'b1, 1'b0, 16'd500, 2'd1, 1'b0, 3'd0},
    {1'b1, 1'b0, 16'd50,  2'd3, 1'b1, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge ref_clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge ref_clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cfg_addr = a;
    #1ns;
    d = cfg_rdata;
  endtask

  task automatic wait_state(input logic [1:0] s, input int maxc, output int n);
    n = 0;
    while (pwr_state != s && n < maxc) begin
      @(negedge ref_clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    logic saw_active;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk("R1 reset state", 32'(pwr_state), 32'd0);
    chk("R1 reset tx_en", 32'(tx_en), 32'd0);
    chk("R1 reset idle", 32'(line_idle), 32'd1);
    chk("R2 reset strobe", 32'(cfg_rst), 32'd0);
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), d);
      chk("R2 reset default", 32'(d), 32'(i * 17));
    end

    for (int v = 0; v < 8; v++) begin
      @(negedge ref_clk);
      link_en  = VECS[v][23];
      mon_park = VECS[v][22];
      mon_half = int'(VECS[v][21:6]);
      cyc(6 * WIN);
      // R3 R4 R6 R1 R9 settled state
      chk("R3/R4 vector state", 32'(pwr_state), 32'(VECS[v][5:4]));
      chk("R3 vector presence", 32'(clk_present), 32'(VECS[v][3]));
      chk("R6 vector tx_en", 32'(tx_en), 32'(VECS[v][5:4] == 2'd3));
      chk("R6 vector idle", 32'(line_idle), 32'(VECS[v][5:4] != 2'd3));
    end

    // R10 write and read back, R5 retention through sleep
    wr(2'd2, 8'h5A);
    rd(2'd2, d);
    chk("R10 readback", 32'(d), 32'h5A);
    mon_half = 0; mon_park = 1'b1;
    wait_state(2'd1, 4 * WIN, n);
    chk("R3 stop to sleep", 32'(pwr_state), 32'd1);
    rd(2'd2, d);
    chk("R5 retained reg2", 32'(d), 32'h5A);
    rd(2'd1, d);
    chk("R5 retained reg1", 32'(d), 32'h11);

    // R6 locking lasts exactly LOCKW windows
    mon_half = 50;
    wait_state(2'd2, 4 * WIN, n);
    chk("R6 entered locking", 32'(pwr_state), 32'd2);
    chk("R6 no tx in locking", 32'(tx_en), 32'd0);
    n = 0;
    while (pwr_state == 2'd2 && n < 5000) begin
      @(negedge ref_clk);
      n++;
    end
    chk("R6 lock duration", 32'(n), 32'(LOCKW * WIN));
    chk("R6 active after lock", 32'(pwr_state), 32'd3);
    rd(2'd2, d);
    chk("R5 retained after relock", 32'(d), 32'h5A);

    // R7 failing window during locking
    mon_half = 0; mon_park = 1'b0;
    wait_state(2'd1, 4 * WIN, n);
    mon_half = 50;
    wait_state(2'd2, 4 * WIN, n);
    mon_half = 0; mon_park = 1'b1;
    saw_active = 1'b0;
    for (int k = 0; k < 3 * WIN; k++) begin
      @(negedge ref_clk);
      if (pwr_state == 2'd3) saw_active = 1'b1;
    end
    chk("R7 never active", 32'(saw_active), 32'd0);
    chk("R7 back to sleep", 32'(pwr_state), 32'd1);

    // R8 capture edge selection
    edge_pin = 1'b1; #1ns;
    chk("R8 pin rising", 32'(cap_rising), 32'd1);
    edge_pin = 1'b0; #1ns;
    chk("R8 pin falling", 32'(cap_rising), 32'd0);
    edge_pin = 1'b1;
    wr(2'd0, 8'h02); #1ns;
    chk("R8 override falling", 32'(cap_rising), 32'd0);
    wr(2'd0, 8'h03); edge_pin = 1'b0; #1ns;
    chk("R8 override rising", 32'(cap_rising), 32'd1);

    // R2 power-down clears registers
    wr(2'd2, 8'h5A);
    mon_half = 50;
    @(negedge ref_clk);
    link_en = 1'b0;
    @(negedge ref_clk);
    chk("R1 off state", 32'(pwr_state), 32'd0);
    chk("R2 strobe high", 32'(cfg_rst), 32'd1);
    chk("R1 off idle", 32'(line_idle), 32'd1);
    @(negedge ref_clk);
    chk("R2 strobe single", 32'(cfg_rst), 32'd0);
    cyc(2);
    rd(2'd2, d);
    chk("R2 reg2 cleared", 32'(d), 32'h22);
    rd(2'd0, d);
    chk("R2 reg0 cleared", 32'(d), 32'h00);
    #1ns;
    chk("R8 pin after clear", 32'(cap_rising), 32'd0);
    wr(2'd1, 8'hFF);
    rd(2'd1, d);
    chk("R2 write ignored in off", 32'(d), 32'h11);

    // R9 release with and without clock
    cyc(3 * WIN);
    chk("R3 present in off", 32'(clk_present), 32'd1);
    link_en = 1'b1;
    @(negedge ref_clk);
    chk("R9 release to locking", 32'(pwr_state), 32'd2);
    link_en = 1'b0;
    mon_half = 0; mon_park = 1'b0;
    cyc(3 * WIN);
    chk("R3 absent in off", 32'(clk_present), 32'd0);
    link_en = 1'b1;
    @(negedge ref_clk);
    chk("R9 release to sleep", 32'(pwr_state), 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule